// File: doc/BRIEF.md
# Network Interface Packetizer

This block sits between a processing element and the injection/ejection ports of a bufferless deflection router. On the transmit side it waits for the application to offer a message. The message carries a payload and the process ID it is meant for. The block takes the message, turns the process ID into a destination switch address through a table, and writes one single-flit packet into the injection FIFO. That packet holds a type code, the destination switch address, this node's own switch address, a per-node message number, a hop counter for the router, and the payload.

On the receive side the block takes one flit from the ejection port and throws away everything except the payload and the sender's switch address. It maps that address back to a process ID through a second table. It then hands the payload and the sender's process ID to the application with a valid/ready handshake.

Both tables are register arrays that load their contents from parameters at reset. A message or packet whose key is missing from its table is dropped, and a one-cycle error flag marks the drop.

Top module: `ni_packetizer`

## Requirements
- R1: While reset is low and in the first cycle after it, `fifo_wr`, `app_tx_ready`, `app_rx_valid`, `tx_miss` and `rx_miss` are 0 and `net_rx_ready` is 1.
- R2: A message to a process ID that the table holds produces one FIFO write. The flit is laid out from MSB to LSB as type code (3 bits, value 3'b010), destination switch address, source switch address, message ID (8 bits), hop count, payload. The destination field is the address that the table maps the process ID to.
- R3: Every written flit has a hop count of 0 and a source field equal to the `MY_ADDR` parameter.
- R4: The message ID of the first packet written after reset is 0. Each later written packet carries the previous ID plus one, modulo 256. A dropped message does not use up an ID.
- R5: While `fifo_full` is 1, no FIFO write happens and `app_tx_ready` stays 0 for a message the table holds. The write and the acknowledge happen together in the first cycle with `fifo_full` at 0.
- R6: A message whose process ID is not in the table is acknowledged with `app_tx_ready` and `tx_miss` high in the same cycle, and no FIFO write happens for it.
- R7: A received flit whose source address is in the table is delivered with `app_rx_data` equal to its payload field and `app_rx_pid` equal to the process ID mapped to that address.
- R8: While `app_rx_valid` is 1 and `app_rx_ready` is 0, the delivered data and process ID hold steady and `net_rx_ready` is 0. After the handshake the block takes the next flit.
- R9: A received flit whose source address is not in the table raises `rx_miss` for one cycle and is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| app_tx_valid | input | 1 | Application offers a message |
| app_tx_pid | input | PID_W | Destination process ID of the message |
| app_tx_data | input | DATA_W | Message payload |
| app_tx_ready | output | 1 | Message consumed (written or dropped) |
| tx_miss | output | 1 | Destination process ID not found; message dropped |
| fifo_full | input | 1 | Injection FIFO cannot take a flit |
| fifo_wr | output | 1 | Injection FIFO write strobe |
| fifo_data | output | FLIT_W | Flit written to the injection FIFO |
| net_rx_valid | input | 1 | Ejection port offers a flit |
| net_rx_flit | input | FLIT_W | Flit from the ejection port |
| net_rx_ready | output | 1 | Block can take a flit |
| app_rx_valid | output | 1 | Received payload available |
| app_rx_data | output | DATA_W | Received payload |
| app_rx_pid | output | PID_W | Process ID of the sender |
| app_rx_ready | input | 1 | Application takes the payload |
| rx_miss | output | 1 | Sender address not found; flit dropped |

## Verification
The bench stalls a message behind a full FIFO. A design that wrote through the full flag, or acknowledged before writing, would lose or duplicate the packet. It runs more than 256 packets so the message ID wraps from 255 to 0, and it drops a message in the middle of a run. A counter that advanced on a drop, or that failed to wrap, would leave a gap in the ID sequence. On receive it holds back the application ready signal, to catch data that changes, or a new flit that is taken, while a delivery is pending. It also sends flits from an unknown sender to make sure nothing reaches the application.

// File: rtl/ni_pkt_pkg.sv
// Shared definitions for the network interface packetizer: the flit type
// code and the state encodings of the transmit and receive sequencers.
package ni_pkt_pkg;

    // Width and value of the flit type code at the top of every flit.
    localparam int          HDR_W     = 3;
    localparam logic [2:0]  HDR_DATA  = 3'b010;

    // Transmit sequencer: wait for a message, resolve its address, push it.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_LOOK = 2'd1,
        TX_PUSH = 2'd2
    } tx_state_e;

    // Receive sequencer: take a flit, resolve the sender, hand it over.
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_LOOK = 2'd1,
        RX_SEND = 2'd2
    } rx_state_e;

endpackage

// File: rtl/ni_map_table.sv
// Key-to-value map built from a register array that loads its contents from
// parameters at reset. The lookup is combinational. Assumes keys are unique.
// If a key appears twice, the lowest entry index wins.
module ni_map_table #(
    parameter int ENTRIES = 4,
    parameter int KEY_W   = 4,
    parameter int VAL_W   = 4,
    parameter logic [ENTRIES*KEY_W-1:0] KEYS = '0,
    parameter logic [ENTRIES*VAL_W-1:0] VALS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key,
    output logic             hit,
    output logic [VAL_W-1:0] val
);

    logic [KEY_W-1:0] key_mem [ENTRIES];
    logic [VAL_W-1:0] val_mem [ENTRIES];

    // One register per entry, loaded from the parameter lists at reset.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_mem[e] <= KEYS[e*KEY_W +: KEY_W];
                val_mem[e] <= VALS[e*VAL_W +: VAL_W];
            end
        end
    end

    // Search from the top so that the lowest matching index is kept last.
    always_comb begin
        hit = 1'b0;
        val = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (key_mem[e] == key) begin
                hit = 1'b1;
                val = val_mem[e];
            end
        end
    end

endmodule

// File: rtl/ni_tx_path.sv
// Transmit sequencer. It captures one message from the application, resolves
// the destination switch address through the external map, and writes one
// flit when the injection FIFO has room. It acknowledges the application in
// the cycle of the write, or in the cycle the lookup misses (drop).
// Assumes the application holds valid and data until it sees ready.
module ni_tx_path
    import ni_pkt_pkg::*;
#(
    parameter int PID_W  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int ID_W   = 8,
    parameter int HOP_W  = 4,
    parameter logic [ADDR_W-1:0] MY_ADDR = '0,
    localparam int FLIT_W = HDR_W + 2*ADDR_W + ID_W + HOP_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app_tx_valid,
    input  logic [PID_W-1:0]  app_tx_pid,
    input  logic [DATA_W-1:0] app_tx_data,
    output logic              app_tx_ready,
    output logic              tx_miss,
    output logic [PID_W-1:0]  lk_pid,
    input  logic              lk_hit,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [FLIT_W-1:0] fifo_data
);

    tx_state_e         state_q;
    logic [PID_W-1:0]  pid_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] dst_q;
    logic [ID_W-1:0]   id_q;

    // Sequencer state, captured message, resolved address and message number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            pid_q   <= '0;
            data_q  <= '0;
            dst_q   <= '0;
            id_q    <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (app_tx_valid) begin
                        pid_q   <= app_tx_pid;
                        data_q  <= app_tx_data;
                        state_q <= TX_LOOK;
                    end
                end
                TX_LOOK: begin
                    if (lk_hit) begin
                        dst_q   <= lk_addr;
                        state_q <= TX_PUSH;
                    end else begin
                        state_q <= TX_IDLE;
                    end
                end
                TX_PUSH: begin
                    if (!fifo_full) begin
                        id_q    <= id_q + 1'b1;
                        state_q <= TX_IDLE;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // Lookup key, strobes and the assembled flit.
    always_comb begin
        lk_pid       = pid_q;
        tx_miss      = (state_q == TX_LOOK) && !lk_hit;
        fifo_wr      = (state_q == TX_PUSH) && !fifo_full;
        app_tx_ready = tx_miss || fifo_wr;
        fifo_data    = {HDR_DATA, dst_q, MY_ADDR, id_q, {HOP_W{1'b0}}, data_q};
    end

endmodule

// File: rtl/ni_rx_path.sv
// Receive sequencer. It takes one flit from the ejection port and keeps only
// the sender address and the payload. It resolves the sender process ID
// through the external map and presents payload plus ID until the application
// takes them. A sender missing from the map drops the flit with a one-cycle
// flag. Only one flit is in flight, so the port is not ready while busy.
module ni_rx_path
    import ni_pkt_pkg::*;
#(
    parameter int PID_W  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int ID_W   = 8,
    parameter int HOP_W  = 4,
    localparam int FLIT_W = HDR_W + 2*ADDR_W + ID_W + HOP_W + DATA_W,
    localparam int SRC_LO = DATA_W + HOP_W + ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_rx_valid,
    input  logic [FLIT_W-1:0] net_rx_flit,
    output logic              net_rx_ready,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_hit,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              app_rx_valid,
    output logic [DATA_W-1:0] app_rx_data,
    output logic [PID_W-1:0]  app_rx_pid,
    input  logic              app_rx_ready,
    output logic              rx_miss
);

    rx_state_e         state_q;
    logic [ADDR_W-1:0] src_q;
    logic [DATA_W-1:0] data_q;
    logic [PID_W-1:0]  pid_q;

    // Sequencer state, stripped fields and the resolved sender ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            src_q   <= '0;
            data_q  <= '0;
            pid_q   <= '0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (net_rx_valid) begin
                        src_q   <= net_rx_flit[SRC_LO +: ADDR_W];
                        data_q  <= net_rx_flit[DATA_W-1:0];
                        state_q <= RX_LOOK;
                    end
                end
                RX_LOOK: begin
                    if (lk_hit) begin
                        pid_q   <= lk_pid;
                        state_q <= RX_SEND;
                    end else begin
                        state_q <= RX_IDLE;
                    end
                end
                RX_SEND: begin
                    if (app_rx_ready) state_q <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // Port readiness, lookup key and delivery outputs.
    always_comb begin
        net_rx_ready = (state_q == RX_IDLE);
        lk_addr      = src_q;
        rx_miss      = (state_q == RX_LOOK) && !lk_hit;
        app_rx_valid = (state_q == RX_SEND);
        app_rx_data  = data_q;
        app_rx_pid   = pid_q;
    end

endmodule

// File: rtl/ni_packetizer.sv
// Network interface packetizer top. It joins the transmit and receive
// sequencers to two maps built from the same parameter lists: process ID to
// switch address for sending, switch address to process ID for receiving.
// Each packet is one flit. Assumes one entry per process ID and per address.
module ni_packetizer
    import ni_pkt_pkg::*;
#(
    parameter int PID_W   = 4,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16,
    parameter int ID_W    = 8,
    parameter int HOP_W   = 4,
    parameter int ENTRIES = 4,
    parameter logic [ADDR_W-1:0] MY_ADDR = 4'd6,
    parameter logic [ENTRIES*PID_W-1:0]  MAP_PID  = {4'd9, 4'd5, 4'd3, 4'd1},
    parameter logic [ENTRIES*ADDR_W-1:0] MAP_ADDR = {4'd12, 4'd7, 4'd5, 4'd2},
    localparam int FLIT_W = HDR_W + 2*ADDR_W + ID_W + HOP_W + DATA_W,
    localparam int HOP_LO = DATA_W,
    localparam int ID_LO  = HOP_LO + HOP_W,
    localparam int SRC_LO = ID_LO + ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app_tx_valid,
    input  logic [PID_W-1:0]  app_tx_pid,
    input  logic [DATA_W-1:0] app_tx_data,
    output logic              app_tx_ready,
    output logic              tx_miss,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [FLIT_W-1:0] fifo_data,
    input  logic              net_rx_valid,
    input  logic [FLIT_W-1:0] net_rx_flit,
    output logic              net_rx_ready,
    output logic              app_rx_valid,
    output logic [DATA_W-1:0] app_rx_data,
    output logic [PID_W-1:0]  app_rx_pid,
    input  logic              app_rx_ready,
    output logic              rx_miss
);

    logic [PID_W-1:0]  tx_key;
    logic              tx_hit;
    logic [ADDR_W-1:0] tx_val;
    logic [ADDR_W-1:0] rx_key;
    logic              rx_hit;
    logic [PID_W-1:0]  rx_val;

    ni_map_table #(
        .ENTRIES(ENTRIES), .KEY_W(PID_W), .VAL_W(ADDR_W),
        .KEYS(MAP_PID), .VALS(MAP_ADDR)
    ) u_pid_to_addr (
        .clk(clk), .rst_n(rst_n), .key(tx_key), .hit(tx_hit), .val(tx_val)
    );

    ni_map_table #(
        .ENTRIES(ENTRIES), .KEY_W(ADDR_W), .VAL_W(PID_W),
        .KEYS(MAP_ADDR), .VALS(MAP_PID)
    ) u_addr_to_pid (
        .clk(clk), .rst_n(rst_n), .key(rx_key), .hit(rx_hit), .val(rx_val)
    );

    ni_tx_path #(
        .PID_W(PID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ID_W(ID_W), .HOP_W(HOP_W), .MY_ADDR(MY_ADDR)
    ) u_tx (
        .clk(clk), .rst_n(rst_n),
        .app_tx_valid(app_tx_valid), .app_tx_pid(app_tx_pid),
        .app_tx_data(app_tx_data), .app_tx_ready(app_tx_ready),
        .tx_miss(tx_miss), .lk_pid(tx_key), .lk_hit(tx_hit),
        .lk_addr(tx_val), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data)
    );

    ni_rx_path #(
        .PID_W(PID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ID_W(ID_W), .HOP_W(HOP_W)
    ) u_rx (
        .clk(clk), .rst_n(rst_n),
        .net_rx_valid(net_rx_valid), .net_rx_flit(net_rx_flit),
        .net_rx_ready(net_rx_ready), .lk_addr(rx_key), .lk_hit(rx_hit),
        .lk_pid(rx_val), .app_rx_valid(app_rx_valid),
        .app_rx_data(app_rx_data), .app_rx_pid(app_rx_pid),
        .app_rx_ready(app_rx_ready), .rx_miss(rx_miss)
    );

endmodule

// File: rtl/ni_packetizer_chk.sv
// Property checker for the packetizer, attached to every instance by bind.
// It sees the FIFO side, both handshakes and the error flags.
module ni_packetizer_chk #(
    parameter int PID_W  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int ID_W   = 8,
    parameter int HOP_W  = 4,
    parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              app_tx_valid,
    input logic              app_tx_ready,
    input logic              tx_miss,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic [HOP_W-1:0]  fifo_hop,
    input logic [ID_W-1:0]   fifo_id,
    input logic [ADDR_W-1:0] fifo_src,
    input logic              net_rx_ready,
    input logic              app_rx_valid,
    input logic [DATA_W-1:0] app_rx_data,
    input logic [PID_W-1:0]  app_rx_pid,
    input logic              app_rx_ready,
    input logic              rx_miss
);

    logic            seen_q;
    logic [ID_W-1:0] last_id_q;

    // Remember the message ID of the latest written flit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            last_id_q <= '0;
        end else if (fifo_wr) begin
            seen_q    <= 1'b1;
            last_id_q <= fifo_id;
        end
    end

    assert_no_write_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full);

    assert_ack_needs_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        app_tx_ready |-> (app_tx_valid && (fifo_wr || tx_miss)));

    assert_fresh_hop_and_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_hop == '0 && fifo_src == MY_ADDR));

    assert_id_steps_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && seen_q) |-> (fifo_id == ID_W'(last_id_q + 1'b1)));

    assert_first_id_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !seen_q) |-> (fifo_id == '0));

    assert_miss_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_miss |-> (app_tx_ready && !fifo_wr));

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (app_rx_valid && !app_rx_ready) |=>
            (app_rx_valid && $stable(app_rx_data) && $stable(app_rx_pid)));

    assert_rx_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        app_rx_valid |-> !net_rx_ready);

    assert_rx_miss_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_miss |=> !app_rx_valid);

endmodule

bind ni_packetizer ni_packetizer_chk #(
    .PID_W(PID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ID_W(ID_W), .HOP_W(HOP_W), .MY_ADDR(MY_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .app_tx_valid(app_tx_valid), .app_tx_ready(app_tx_ready),
    .tx_miss(tx_miss), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
    .fifo_hop(fifo_data[HOP_LO +: HOP_W]),
    .fifo_id(fifo_data[ID_LO +: ID_W]),
    .fifo_src(fifo_data[SRC_LO +: ADDR_W]),
    .net_rx_ready(net_rx_ready), .app_rx_valid(app_rx_valid),
    .app_rx_data(app_rx_data), .app_rx_pid(app_rx_pid),
    .app_rx_ready(app_rx_ready), .rx_miss(rx_miss)
);

// File: tb/ni_packetizer_test.sv
`timescale 1ns/1ps
// Directed bench for the packetizer: one task per scenario, each task checks
// its own results. Expected values come from the requirement text.
module ni_packetizer_test;

    localparam int FW = 39;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          app_tx_valid = 1'b0;
    logic [3:0]    app_tx_pid = '0;
    logic [15:0]   app_tx_data = '0;
    logic          app_tx_ready;
    logic          tx_miss;
    logic          fifo_full = 1'b0;
    logic          fifo_wr;
    logic [FW-1:0] fifo_data;
    logic          net_rx_valid = 1'b0;
    logic [FW-1:0] net_rx_flit = '0;
    logic          net_rx_ready;
    logic          app_rx_valid;
    logic [15:0]   app_rx_data;
    logic [3:0]    app_rx_pid;
    logic          app_rx_ready = 1'b0;
    logic          rx_miss;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_id = 8'd0;

    always #2 clk = ~clk;

    ni_packetizer uut (
        .clk(clk), .rst_n(rst_n),
        .app_tx_valid(app_tx_valid), .app_tx_pid(app_tx_pid),
        .app_tx_data(app_tx_data), .app_tx_ready(app_tx_ready),
        .tx_miss(tx_miss), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .net_rx_valid(net_rx_valid),
        .net_rx_flit(net_rx_flit), .net_rx_ready(net_rx_ready),
        .app_rx_valid(app_rx_valid), .app_rx_data(app_rx_data),
        .app_rx_pid(app_rx_pid), .app_rx_ready(app_rx_ready),
        .rx_miss(rx_miss)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Expected flit for a written packet, built from the R2 layout.
    function automatic logic [FW-1:0] mk_flit(input logic [3:0] dst, input logic [3:0] src,
                                               input logic [7:0] id, input logic [15:0] d);
        return {3'b010, dst, src, id, 4'd0, d};
    endfunction

    // Offer one message and wait for its acknowledge; report what was seen.
    task automatic tx_msg(input logic [3:0] pid, input logic [15:0] d,
                          output bit acked, output bit wr, output bit miss,
                          output logic [FW-1:0] flit);
        @(negedge clk);
        app_tx_pid = pid; app_tx_data = d; app_tx_valid = 1'b1;
        acked = 0; wr = 0; miss = 0; flit = '0;
        for (int n = 0; n < 20 && !acked; n++) begin
            #1;
            if (app_tx_ready) begin
                acked = 1; wr = fifo_wr; miss = tx_miss; flit = fifo_data;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        app_tx_valid = 1'b0;
    endtask

    // Send one message that must be written with address dst (R2, R3, R4).
    task automatic tx_expect_write(input logic [3:0] pid, input logic [3:0] dst,
                                   input logic [15:0] d);
        bit a, w, m; logic [FW-1:0] f;
        tx_msg(pid, d, a, w, m, f);
        check(a && w && !m, "R2 write strobe", {w, m}, 2'b10);
        check(f == mk_flit(dst, 4'd6, exp_id, d), "R2/R3/R4 flit", f, mk_flit(dst, 4'd6, exp_id, d));
        exp_id = exp_id + 8'd1;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(!fifo_wr && !app_tx_ready && !app_rx_valid && !tx_miss && !rx_miss,
              "R1 outputs in reset", {fifo_wr, app_tx_ready, app_rx_valid, tx_miss, rx_miss}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!fifo_wr && !app_tx_ready && !app_rx_valid && net_rx_ready,
              "R1 outputs after reset", {fifo_wr, app_tx_ready, app_rx_valid, net_rx_ready}, 1);
    endtask

    task automatic test_tx_basic();
        tx_expect_write(4'd1, 4'd2,  16'hA5A5);
        tx_expect_write(4'd9, 4'd12, 16'h0001);
        tx_expect_write(4'd3, 4'd5,  16'hFFFF);
        tx_expect_write(4'd5, 4'd7,  16'h1234);
    endtask

    task automatic test_tx_stall();
        bit wr_seen = 0, ack_seen = 0;
        @(negedge clk);
        fifo_full = 1'b1;
        app_tx_pid = 4'd5; app_tx_data = 16'hBEEF; app_tx_valid = 1'b1;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk); #1;
            if (fifo_wr) wr_seen = 1;
            if (app_tx_ready) ack_seen = 1;
        end
        check(!wr_seen && !ack_seen, "R5 no write or ack while full", {wr_seen, ack_seen}, 0);
        fifo_full = 1'b0;
        #1;
        check(fifo_wr && app_tx_ready, "R5 write and ack once room", {fifo_wr, app_tx_ready}, 2'b11);
        check(fifo_data == mk_flit(4'd7, 4'd6, exp_id, 16'hBEEF), "R5 stalled flit",
              fifo_data, mk_flit(4'd7, 4'd6, exp_id, 16'hBEEF));
        exp_id = exp_id + 8'd1;
        @(negedge clk);
        app_tx_valid = 1'b0;
    endtask

    task automatic test_tx_miss();
        bit a, w, m; logic [FW-1:0] f;
        tx_msg(4'd4, 16'hDEAD, a, w, m, f);
        check(a && m && !w, "R6 unknown pid dropped", {a, m, w}, 3'b110);
        tx_msg(4'd15, 16'hCAFE, a, w, m, f);
        check(a && m && !w, "R6 second unknown pid dropped", {a, m, w}, 3'b110);
        // The next good message must carry the next unused ID (R4).
        tx_expect_write(4'd1, 4'd2, 16'h7777);
    endtask

    task automatic test_id_wrap();
        bit a, w, m; logic [FW-1:0] f;
        int bad = 0;
        for (int n = 0; n < 260; n++) begin
            tx_msg(4'd3, 16'(n), a, w, m, f);
            if (!(w && f[27:20] == exp_id)) bad++;
            exp_id = exp_id + 8'd1;
        end
        check(bad == 0, "R4 ID sequence across wrap", bad, 0);
        tx_expect_write(4'd9, 4'd12, 16'h5A5A);
    endtask

    // Deliver one flit from src; expect pid, holding ready low for hold cycles.
    task automatic rx_hit(input logic [3:0] src, input logic [3:0] pid,
                          input logic [15:0] d, input int hold);
        bit got = 0, stable_ok = 1;
        @(negedge clk);
        app_rx_ready = 1'b0;
        net_rx_flit = {3'b010, 4'd6, src, 8'h3C, 4'd5, d};
        net_rx_valid = 1'b1;
        @(negedge clk);
        net_rx_valid = 1'b0;
        for (int n = 0; n < 10 && !got; n++) begin
            #1;
            if (app_rx_valid) got = 1; else @(negedge clk);
        end
        check(got, "R7 delivery", got, 1);
        check(app_rx_data == d && app_rx_pid == pid, "R7 payload and pid",
              {app_rx_data, app_rx_pid}, {d, pid});
        for (int n = 0; n < hold; n++) begin
            @(negedge clk); #1;
            if (!(app_rx_valid && app_rx_data == d && app_rx_pid == pid && !net_rx_ready))
                stable_ok = 0;
        end
        check(stable_ok, "R8 held while not taken", stable_ok, 1);
        app_rx_ready = 1'b1;
        @(negedge clk); #1;
        check(!app_rx_valid && net_rx_ready, "R8 released after handshake",
              {app_rx_valid, net_rx_ready}, 2'b01);
        app_rx_ready = 1'b0;
    endtask

    task automatic test_rx_basic();
        rx_hit(4'd2,  4'd1, 16'h0F0F, 0);
        rx_hit(4'd12, 4'd9, 16'h8001, 0);
    endtask

    task automatic test_rx_hold();
        rx_hit(4'd7, 4'd5, 16'h4242, 5);
        rx_hit(4'd5, 4'd3, 16'hC3C3, 2);
    endtask

    task automatic test_rx_miss();
        bit miss_seen = 0, valid_seen = 0;
        @(negedge clk);
        app_rx_ready = 1'b1;
        net_rx_flit = {3'b010, 4'd6, 4'd9, 8'h01, 4'd2, 16'h9999};
        net_rx_valid = 1'b1;
        @(negedge clk);
        net_rx_valid = 1'b0;
        for (int n = 0; n < 6; n++) begin
            #1;
            if (rx_miss) miss_seen = 1;
            if (app_rx_valid) valid_seen = 1;
            @(negedge clk);
        end
        check(miss_seen && !valid_seen, "R9 unknown sender dropped", {miss_seen, valid_seen}, 2'b10);
        app_rx_ready = 1'b0;
        rx_hit(4'd2, 4'd1, 16'h1111, 1);
    endtask

    initial begin
        test_reset();
        test_tx_basic();
        test_tx_stall();
        test_tx_miss();
        test_id_wrap();
        test_rx_basic();
        test_rx_hold();
        test_rx_miss();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

endmodule